// File: doc/BRIEF.md
# I2C Receiver Acknowledge Controller

This block sits beside the bit engine of an I2C receiver. For every byte that comes in, it decides whether the acknowledge clock carries an ACK (SDA pulled low) or a NACK (SDA left released). It works in both the slave-receiver and the master-receiver role.

It follows the bus through single-cycle strobes: SCL rising, SCL falling and byte-complete. The NACK decision combines several sources:
- a one-shot request from the host;
- the transfer-enable input;
- a receive-overrun condition;
- a loadable byte counter that can end a master read with an automatic STOP;
- a soft reset.

It also issues STOP requests to the master bit engine. It reports every refused byte with a pulse and a one-bit cause.

The control is a four-state machine:
- `ST_IDLE`: held while soft reset is asserted. It goes to `ST_DATA` once soft reset drops.
- `ST_DATA`: counts the data-bit rising edges. It goes to `ST_ARM` on the byte-complete strobe and latches the verdict at that point.
- `ST_ARM`: waits for the 8th SCL fall. On that fall it goes to `ST_SLOT` and starts or withholds the SDA drive.
- `ST_SLOT`: the acknowledge clock. On the 9th SCL fall it returns to `ST_DATA`, releases SDA and may request STOP.

Soft reset moves any state to `ST_IDLE` at once. The byte-complete strobe must come after the 8th rising strobe and before the 8th falling strobe.

Top module: `rx_ack_ctrl`

## Requirements
- R1: With no NACK source active, `sda_low` is 1 throughout the acknowledge slot, and `nack_sent` stays 0.
- R2: `sda_low` changes only on the cycle after an SCL falling strobe or a soft reset. It becomes valid after the 8th data-bit fall, holds through the 9th rise, and returns to 0 after the 9th fall.
- R3: A `nack_req` pulse seen strictly before the 8th rising strobe of a byte NACKs that byte. A pulse on or after that strobe NACKs the next byte instead. A request clears itself once used, so the following byte is ACKed.
- R4: In the slave role (`role_master`=0), `xfer_en`=0 makes the block NACK the byte.
- R5: `rx_full` is set by every byte-complete strobe and cleared by `rd_strobe`. In the slave role, a byte that completes while `rx_full` is 1 is NACKed.
- R6: In master repeat mode (`role_master`=1, `repeat_mode`=1), the counter is ignored and only the request source NACKs. A one-cycle `stop_req` follows the 9th fall only when that byte was NACKed and `stop_in`=1.
- R7: In master non-repeat mode with `stop_on_count`=1, each byte decrements the counter. The byte that takes it from 1 to 0 is NACKed and is followed by a `stop_req` pulse after the 9th fall. A count of 0 never wraps.
- R8: In master non-repeat mode, a 0-to-1 change of `stop_on_count` outside soft reset gives a `stop_req` pulse on the next cycle.
- R9: `soft_rst` releases `sda_low` on the next cycle and returns to `ST_IDLE`. It also discards any pending request and clears `rx_full`.
- R10: Each NACKed byte gives a one-cycle `nack_sent` pulse after the 8th fall. `nack_cause` is 1 when the refusal came from an overrun and 0 when it came from a request, disable or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low hard reset, sampled on clk |
| soft_rst | input | 1 | Soft reset: aborts reception, releases SDA |
| scl_rise | input | 1 | One-cycle strobe at each SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe at each SCL falling edge |
| byte_done | input | 1 | One-cycle strobe when 8 data bits are in |
| rd_strobe | input | 1 | Host read of the received byte, clears `rx_full` |
| nack_req | input | 1 | One-shot NACK request pulse |
| role_master | input | 1 | 1 = master receiver, 0 = slave receiver |
| repeat_mode | input | 1 | 1 = counter ignored (master) |
| stop_on_count | input | 1 | Enables counting down to an automatic STOP |
| stop_in | input | 1 | STOP wanted after a NACK in repeat mode |
| xfer_en | input | 1 | Slave transfer enable |
| cnt_load | input | 1 | Loads the byte counter |
| cnt_val | input | CNT_W | Value loaded into the byte counter |
| sda_low | output | 1 | 1 = pull SDA low (ACK) |
| stop_req | output | 1 | One-cycle STOP request to the bit engine |
| nack_sent | output | 1 | One-cycle pulse per NACKed byte |
| nack_cause | output | 1 | 1 = overrun, 0 = request/disable/count |
| rx_full | output | 1 | Received-byte-pending flag |

## Verification
The main sweep crosses every combination of:
- role and repeat mode;
- stop-on-count;
- transfer enable;
- a full or empty receive flag;
- a counter of 1 or 2;
- `stop_in`;
- a request that arrives early, late or not at all.

Each crossed byte is followed by a plain byte, which separates a request that lands on the current byte from one that carries over, and shows that a used request has cleared. Crossing the overrun and disable sources with the request separates the cause codes. The counter values 1 and 2 separate exhaustion from plain decrement. Directed cases cover:
- a soft reset in the middle of the acknowledge slot;
- a soft reset that discards a pending request;
- a late rise of stop-on-count.

// File: rtl/rx_ack_pkg.sv
package rx_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_ARM,
        ST_SLOT
    } ack_state_e;

    typedef struct packed {
        logic nack;
        logic cause;
        logic stop;
    } ack_verdict_t;

    localparam logic CAUSE_OVERRUN = 1'b1;
    localparam logic CAUSE_OTHER   = 1'b0;

endpackage

// File: rtl/rx_ack_bitcnt.sv
module rx_ack_bitcnt #(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic rise,
    output logic last_rise
);
    localparam int W = $clog2(BITS + 1);
    localparam logic [W-1:0] LAST = W'(BITS - 1);
    localparam logic [W-1:0] FULL = W'(BITS);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && rise && cnt_q != FULL) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign last_rise = en && rise && (cnt_q == LAST);

    // R2: the bit position never runs past one byte
    assert_bit_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

endmodule

// File: rtl/rx_ack_bytecnt.sv
module rx_ack_bytecnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign at_last = (cnt_q == ONE);

    // R7: an exhausted counter stays at zero until reloaded
    assert_cnt_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> cnt_q == '0);

endmodule

// File: rtl/rx_ack_policy.sv
module rx_ack_policy
    import rx_ack_pkg::*;
(
    input  logic         role_master,
    input  logic         repeat_mode,
    input  logic         stop_on_count,
    input  logic         stop_in,
    input  logic         xfer_en,
    input  logic         overrun,
    input  logic         req_hit,
    input  logic         cnt_last,
    output ack_verdict_t verdict
);
    logic exhausted;

    assign exhausted = stop_on_count && cnt_last;

    always_comb begin
        verdict = '0;
        if (!role_master) begin
            verdict.nack  = req_hit || !xfer_en || overrun;
            verdict.cause = overrun ? CAUSE_OVERRUN : CAUSE_OTHER;
        end else if (repeat_mode) begin
            verdict.nack = req_hit;
            verdict.stop = req_hit && stop_in;
        end else begin
            verdict.nack = req_hit || exhausted;
            verdict.stop = exhausted;
        end
    end

endmodule

// File: rtl/rx_ack_ctrl.sv
module rx_ack_ctrl
    import rx_ack_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             byte_done,
    input  logic             rd_strobe,
    input  logic             nack_req,
    input  logic             role_master,
    input  logic             repeat_mode,
    input  logic             stop_on_count,
    input  logic             stop_in,
    input  logic             xfer_en,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    output logic             sda_low,
    output logic             stop_req,
    output logic             nack_sent,
    output logic             nack_cause,
    output logic             rx_full
);
    ack_state_e   state_q, state_d;
    ack_verdict_t verdict, dec_q;
    logic in_data, take_byte, last_rise, cnt_last, cnt_dec;
    logic pend_q, snap_q, soc_q, soc_rose;

    assign in_data   = (state_q == ST_DATA);
    assign take_byte = in_data && byte_done;
    assign cnt_dec   = take_byte && role_master && !repeat_mode && stop_on_count;
    assign soc_rose  = stop_on_count && !soc_q && role_master && !repeat_mode
                       && (state_q != ST_IDLE) && !soft_rst;

    rx_ack_bitcnt #(.BITS(BITS)) u_bitcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!in_data),
        .en       (in_data),
        .rise     (scl_rise),
        .last_rise(last_rise)
    );

    rx_ack_bytecnt #(.CNT_W(CNT_W)) u_bytecnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .at_last (cnt_last)
    );

    rx_ack_policy u_policy (
        .role_master  (role_master),
        .repeat_mode  (repeat_mode),
        .stop_on_count(stop_on_count),
        .stop_in      (stop_in),
        .xfer_en      (xfer_en),
        .overrun      (rx_full),
        .req_hit      (snap_q),
        .cnt_last     (cnt_last),
        .verdict      (verdict)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_DATA;
            ST_DATA: if (byte_done) state_d = ST_ARM;
            ST_ARM:  if (scl_fall)  state_d = ST_SLOT;
            ST_SLOT: if (scl_fall)  state_d = ST_DATA;
            default: state_d = ST_IDLE;
        endcase
        if (soft_rst) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request latch, snapshot at the last data-bit rise, verdict and full flag
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pend_q  <= 1'b0;
            snap_q  <= 1'b0;
            dec_q   <= '0;
            rx_full <= 1'b0;
        end else begin
            if (last_rise) begin
                snap_q <= pend_q;
                pend_q <= nack_req;
            end else begin
                pend_q <= pend_q || nack_req;
            end
            if (take_byte) begin
                dec_q   <= verdict;
                rx_full <= 1'b1;
            end else if (rd_strobe) begin
                rx_full <= 1'b0;
            end
            if (state_q == ST_SLOT && scl_fall) snap_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) soc_q <= 1'b0;
        else        soc_q <= stop_on_count;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sda_low    <= 1'b0;
            stop_req   <= 1'b0;
            nack_sent  <= 1'b0;
            nack_cause <= 1'b0;
        end else begin
            nack_sent <= 1'b0;
            stop_req  <= soc_rose;
            unique case (state_q)
                ST_ARM: if (scl_fall) begin
                    sda_low    <= !dec_q.nack;
                    nack_sent  <= dec_q.nack;
                    nack_cause <= dec_q.cause;
                end
                ST_SLOT: if (scl_fall) begin
                    sda_low  <= 1'b0;
                    stop_req <= dec_q.stop || soc_rose;
                end
                default: ;
            endcase
        end
    end

    // R2: SDA drive moves only while SCL is low (after a fall) or on soft reset
    assert_sda_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_low != $past(sda_low)) |-> ($past(scl_fall) || $past(soft_rst)));

    // R9: soft reset releases SDA on the following cycle
    assert_softrst_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !sda_low);

    // R10: a refused byte is never driven low
    assert_nack_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nack_sent |-> !sda_low);

    // R7: STOP requests are only issued in the master role
    assert_stop_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> $past(role_master));

endmodule

// File: tb/rx_ack_ctrl_tb_top.sv
module rx_ack_ctrl_tb_top;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0, byte_done = 1'b0;
    logic rd_strobe = 1'b0, nack_req = 1'b0;
    logic role_master = 1'b0, repeat_mode = 1'b0, stop_on_count = 1'b0;
    logic stop_in = 1'b0, xfer_en = 1'b1, cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic sda_low, stop_req, nack_sent, nack_cause, rx_full;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_ack_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .byte_done(byte_done), .rd_strobe(rd_strobe),
        .nack_req(nack_req), .role_master(role_master), .repeat_mode(repeat_mode),
        .stop_on_count(stop_on_count), .stop_in(stop_in), .xfer_en(xfer_en),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .sda_low(sda_low),
        .stop_req(stop_req), .nack_sent(nack_sent), .nack_cause(nack_cause),
        .rx_full(rx_full)
    );

    task automatic check_eq(input string rq, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic p_rise();
        @(negedge clk) scl_rise = 1'b1;
        @(negedge clk) scl_rise = 1'b0;
    endtask
    task automatic p_fall();
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask
    task automatic p_done();
        @(negedge clk) byte_done = 1'b1;
        @(negedge clk) byte_done = 1'b0;
    endtask
    task automatic p_req();
        @(negedge clk) nack_req = 1'b1;
        @(negedge clk) nack_req = 1'b0;
    endtask
    task automatic p_rd();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic do_soft_reset(input logic [CNT_W-1:0] cnt);
        @(negedge clk);
        soft_rst = 1'b1; cnt_load = 1'b1; cnt_val = cnt;
        role_master = 1'b1; repeat_mode = 1'b1; stop_on_count = 1'b0;
        stop_in = 1'b0; xfer_en = 1'b1;
        @(negedge clk) cnt_load = 1'b0;
        @(negedge clk) soft_rst = 1'b0;
        @(negedge clk);
    endtask

    // one byte; early/late place a request before/after the 8th rise
    task automatic run_byte(input bit early, input bit late,
                            output bit drv, output bit ns, output bit cs, output bit sp);
        drv = 1'b0; ns = 1'b0; cs = 1'b0;
        for (int b = 0; b < 8; b++) begin
            if (b == 7 && early) p_req();
            p_rise();
            if (b == 7) begin
                if (late) p_req();
                p_done();
                check_eq("R2 sda idle before 8th fall", int'(sda_low), 0);
            end
            p_fall();
            if (b == 7) begin
                drv = sda_low; ns = nack_sent; cs = nack_cause;
            end
        end
        p_rise();
        check_eq("R2 sda held through 9th rise", int'(sda_low), int'(drv));
        p_fall();
        sp = stop_req;
        check_eq("R2 sda released after 9th fall", int'(sda_low), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit drv, ns, cs, sp;
        repeat (3) @(negedge clk);
        check_eq("R9 reset sda_low", int'(sda_low), 0);
        check_eq("R9 reset stop_req", int'(stop_req), 0);
        check_eq("R10 reset nack_sent", int'(nack_sent), 0);
        check_eq("R5 reset rx_full", int'(rx_full), 0);
        rst_n = 1'b1;
        do_soft_reset(4'd1);

        // R1 plain byte
        run_byte(1'b0, 1'b0, drv, ns, cs, sp);
        check_eq("R1 plain ack", int'(drv), 1);
        check_eq("R1 no nack pulse", int'(ns), 0);
        check_eq("R5 rx_full set", int'(rx_full), 1);
        p_rd();
        check_eq("R5 rx_full cleared by read", int'(rx_full), 0);

        // main sweep
        for (int rm = 0; rm < 2; rm++)
        for (int rp = 0; rp < 2; rp++)
        for (int sc = 0; sc < 2; sc++)
        for (int xe = 0; xe < 2; xe++)
        for (int fl = 0; fl < 2; fl++)
        for (int cn = 1; cn < 3; cn++)
        for (int si = 0; si < 2; si++)
        for (int tm = 0; tm < 3; tm++) begin
            bit early, late, e_nack, e_cause, e_stop, ovr;
            early = (tm == 1); late = (tm == 2);
            do_soft_reset(CNT_W'(cn));
            if (fl == 1) run_byte(1'b0, 1'b0, drv, ns, cs, sp);
            @(negedge clk);
            role_master = rm[0]; repeat_mode = rp[0]; stop_on_count = sc[0];
            xfer_en = xe[0]; stop_in = si[0];
            repeat (2) @(negedge clk);
            ovr = (rm == 0) && (fl == 1);
            if (rm == 0) begin
                e_nack = early || (xe == 0) || (fl == 1);
                e_cause = ovr; e_stop = 1'b0;
            end else if (rp == 1) begin
                e_nack = early; e_cause = 1'b0; e_stop = early && (si == 1);
            end else begin
                e_nack = early || (sc == 1 && cn == 1);
                e_cause = 1'b0; e_stop = (sc == 1 && cn == 1);
            end
            run_byte(early, late, drv, ns, cs, sp);
            check_eq("R3 R4 R5 R6 R7 ack level", int'(drv), int'(!e_nack));
            check_eq("R10 nack pulse", int'(ns), int'(e_nack));
            if (e_nack) check_eq("R10 R5 cause code", int'(cs), int'(e_cause));
            check_eq("R6 R7 stop after slot", int'(sp), int'(e_stop));
            p_rd();
            @(negedge clk);
            role_master = 1'b1; repeat_mode = 1'b1; stop_in = 1'b0; xfer_en = 1'b1;
            repeat (2) @(negedge clk);
            run_byte(1'b0, 1'b0, drv, ns, cs, sp);
            check_eq("R3 follow-up byte carries late request only", int'(drv), int'(!late));
            check_eq("R3 follow-up stop", int'(sp), 0);
        end

        // R7 counter 2: first ACK, second NACK + STOP
        do_soft_reset(4'd2);
        @(negedge clk) begin repeat_mode = 1'b0; stop_on_count = 1'b1; end
        run_byte(1'b0, 1'b0, drv, ns, cs, sp);
        check_eq("R7 count 2->1 acked", int'(drv), 1);
        check_eq("R7 count 2->1 no stop", int'(sp), 0);
        run_byte(1'b0, 1'b0, drv, ns, cs, sp);
        check_eq("R7 count 1->0 nacked", int'(drv), 0);
        check_eq("R7 count 1->0 stop", int'(sp), 1);
        run_byte(1'b0, 1'b0, drv, ns, cs, sp);
        check_eq("R7 zero count does not wrap", int'(sp), 0);

        // R8 late set of stop-on-count
        do_soft_reset(4'd5);
        @(negedge clk) repeat_mode = 1'b0;
        @(negedge clk) stop_on_count = 1'b1;
        @(negedge clk);
        check_eq("R8 stop on late stop_on_count", int'(stop_req), 1);
        @(negedge clk);
        check_eq("R8 single pulse", int'(stop_req), 0);

        // R9 soft reset inside the ack slot
        do_soft_reset(4'd3);
        for (int b = 0; b < 8; b++) begin
            p_rise();
            if (b == 7) p_done();
            p_fall();
        end
        check_eq("R9 driving before abort", int'(sda_low), 1);
        soft_rst = 1'b1;
        @(negedge clk);
        check_eq("R9 release on soft reset", int'(sda_low), 0);
        check_eq("R9 rx_full cleared", int'(rx_full), 0);
        soft_rst = 1'b0;
        repeat (2) @(negedge clk);
        run_byte(1'b0, 1'b0, drv, ns, cs, sp);
        check_eq("R9 clean byte after abort", int'(drv), 1);

        // R9 pending request discarded
        p_req();
        do_soft_reset(4'd3);
        run_byte(1'b0, 1'b0, drv, ns, cs, sp);
        check_eq("R9 pending request discarded", int'(drv), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule